// File: doc/BRIEF.md
# Programmable Interrupt Countdown Timer

This block is a down-counting timer that raises an interrupt request when its count runs out. Software programs it through a small word-addressed register bus. There are four registers: a start value, a live count that can only be read, a clock-divider setting and an interrupt entry. The interrupt entry holds the request vector, a mask and a mode select that chooses between a single expiry and repeated expiries. Each decrement of the live count takes a programmable number of input clocks.

On expiry the block sends a one-cycle request that carries the 8-bit vector. A separate interrupt controller consumes this request. In repeating mode the live count reloads from the start value and counting continues. In single mode the count stays at zero and the timer stops. The mask suppresses the request only; the counting itself is unaffected.

Register word addresses on `bus_addr`: 0 = start value, 1 = live count (read only), 2 = divider setting, 3 = interrupt entry. Reads are combinational from `bus_addr`. A write takes effect at the rising edge on which `bus_we` is high.

Top module: `irq_countdown_timer`

## Requirements
- R1: After reset the live count is 0, the timer is stopped, `irq_valid` is low and all four registers read 0.
- R2: Writing a nonzero start value N loads N into the live count and starts the timer. Writing 0 clears the live count, stops the timer and raises no request.
- R3: The divider code is {bit3, bit1, bit0} of the written word. Code 7 selects a factor of 1, and code c in 0..6 selects a factor of 2<<c (2 to 128). The register reads back only bits 3, 1 and 0; every other bit reads 0.
- R4: While running, the live count drops by one every F clocks, where F is the divider factor. With start value N, the request appears N*F clocks after the start-value write edge.
- R5: When interrupt-entry bit 17 is 1 (repeating mode), an expiry reloads the live count with the start value, and the next expiry follows N*F clocks later.
- R6: When bit 17 is 0 (single mode), an expiry leaves the live count at 0 and stops the timer. No further request follows.
- R7: When interrupt-entry bit 16 (mask) is 1, an expiry raises no request, but counting and reloading continue unchanged.
- R8: A request is `irq_valid` high for one clock, with `irq_vector` equal to interrupt-entry bits 7:0.
- R9: The interrupt entry keeps only bits 7:0, 12, 16 and 17 of a write, and reads back as the written word ANDed with 0x000310FF.
- R10: A start-value write while the timer runs restarts the count from the new value with a fresh divider phase.
- R11: A divider-setting write restarts the divider phase: no decrement occurs at that edge, and the next decrement comes F clocks later.
- R12: Writes to the live-count address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector carried with the request |

## Verification
The assertions assume that reset is high at the first rising edge. They also assume that `bus_we`, `bus_addr` and `bus_wdata` hold defined values at every edge after reset. The bench meets both conditions: it holds reset for several clocks and changes inputs only on falling edges. The bench's own checks sweep all eight divider codes, with extra bits set in the written word. It also covers two boundary cases: a start value of 1 at factor 1 in repeating mode, which gives a request on every clock, and a divider write in the middle of a prescale window.

// File: rtl/irqtmr_pkg.sv
package irqtmr_pkg;

    localparam int BUS_W      = 32;
    localparam int VEC_W      = 8;
    localparam int CODE_W     = 3;
    localparam int PRE_W      = 7;
    localparam logic [CODE_W-1:0] CODE_UNITY = 3'd7;

    typedef enum logic [1:0] {
        SEL_START = 2'd0,
        SEL_LIVE  = 2'd1,
        SEL_DIV   = 2'd2,
        SEL_ENTRY = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             repeat_mode;
        logic             masked;
        logic             dstat;
        logic [VEC_W-1:0] vector;
    } irq_entry_t;

    function automatic logic [CODE_W-1:0] word_to_code(input logic [BUS_W-1:0] w);
        return {w[3], w[1], w[0]};
    endfunction

    function automatic logic [BUS_W-1:0] code_to_word(input logic [CODE_W-1:0] c);
        return {28'd0, c[2], 1'b0, c[1], c[0]};
    endfunction

    function automatic logic [PRE_W-1:0] code_to_limit(input logic [CODE_W-1:0] c);
        logic [PRE_W:0] factor;
        factor = (PRE_W+1)'(2) << c;
        if (c == CODE_UNITY)
            return '0;
        return PRE_W'(factor - (PRE_W+1)'(1));
    endfunction

    function automatic irq_entry_t word_to_entry(input logic [BUS_W-1:0] w);
        irq_entry_t e;
        e.repeat_mode = w[17];
        e.masked      = w[16];
        e.dstat       = w[12];
        e.vector      = w[VEC_W-1:0];
        return e;
    endfunction

    function automatic logic [BUS_W-1:0] entry_to_word(input irq_entry_t e);
        return {14'd0, e.repeat_mode, e.masked, 3'd0, e.dstat, 4'd0, e.vector};
    endfunction

endpackage

// File: rtl/irqtmr_cfg_regs.sv
module irqtmr_cfg_regs
    import irqtmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [BUS_W-1:0]  wdata,
    output logic [CNT_W-1:0]  start_q,
    output logic [CODE_W-1:0] code_q,
    output irq_entry_t        entry_q,
    output logic              load_stb,
    output logic              div_stb
);
    reg_sel_e sel_e;
    assign sel_e    = reg_sel_e'(sel);
    assign load_stb = we && (sel_e == SEL_START);
    assign div_stb  = we && (sel_e == SEL_DIV);

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            code_q  <= '0;
            entry_q <= '0;
        end else begin
            if (load_stb)
                start_q <= wdata[CNT_W-1:0];
            if (div_stb)
                code_q <= word_to_code(wdata);
            if (we && (sel_e == SEL_ENTRY))
                entry_q <= word_to_entry(wdata);
        end
    end
endmodule

// File: rtl/irqtmr_prescaler.sv
module irqtmr_prescaler #(
    parameter int PRE_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [PRE_W-1:0] limit,
    output logic             tick
);
    logic [PRE_W-1:0] phase_q;
    logic             at_end;

    assign at_end = (phase_q >= limit);
    assign tick   = run && !restart && at_end;

    always_ff @(posedge clk) begin
        if (rst || restart || !run)
            phase_q <= '0;
        else if (at_end)
            phase_q <= '0;
        else
            phase_q <= phase_q + PRE_W'(1);
    end
endmodule

// File: rtl/irqtmr_down_counter.sv
module irqtmr_down_counter
    import irqtmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  irq_entry_t       entry,
    output logic [CNT_W-1:0] cur_q,
    output logic             running_q,
    output logic             fire_q,
    output logic [VEC_W-1:0] vec_q
);
    logic last_step;
    assign last_step = running_q && tick && (cur_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q     <= '0;
            running_q <= 1'b0;
            fire_q    <= 1'b0;
            vec_q     <= '0;
        end else begin
            fire_q <= 1'b0;
            if (load) begin
                cur_q     <= load_val;
                running_q <= (load_val != '0);
            end else if (last_step) begin
                if (!entry.masked) begin
                    fire_q <= 1'b1;
                    vec_q  <= entry.vector;
                end
                if (entry.repeat_mode) begin
                    cur_q <= load_val;
                end else begin
                    cur_q     <= '0;
                    running_q <= 1'b0;
                end
            end else if (running_q && tick) begin
                cur_q <= cur_q - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer
    import irqtmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_we,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_valid,
    output logic [7:0]  irq_vector
);
    logic [CNT_W-1:0]  start_q;
    logic [CODE_W-1:0] code_q;
    irq_entry_t        entry_q;
    logic              load_stb;
    logic              div_stb;
    logic              tick;
    logic [CNT_W-1:0]  cur_q;
    logic              running_q;

    irqtmr_cfg_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (bus_we),
        .sel      (bus_addr),
        .wdata    (bus_wdata),
        .start_q  (start_q),
        .code_q   (code_q),
        .entry_q  (entry_q),
        .load_stb (load_stb),
        .div_stb  (div_stb)
    );

    irqtmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (running_q),
        .restart (load_stb || div_stb),
        .limit   (code_to_limit(code_q)),
        .tick    (tick)
    );

    irqtmr_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .load      (load_stb),
        .load_val  (load_stb ? bus_wdata[CNT_W-1:0] : start_q),
        .tick      (tick),
        .entry     (entry_q),
        .cur_q     (cur_q),
        .running_q (running_q),
        .fire_q    (irq_valid),
        .vec_q     (irq_vector)
    );

    always_comb begin
        case (reg_sel_e'(bus_addr))
            SEL_START: bus_rdata = BUS_W'(start_q);
            SEL_LIVE:  bus_rdata = BUS_W'(cur_q);
            SEL_DIV:   bus_rdata = code_to_word(code_q);
            default:   bus_rdata = entry_to_word(entry_q);
        endcase
    end
endmodule

// File: rtl/irqtmr_checker.sv
module irqtmr_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_we,
    input logic [1:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic             irq_valid,
    input logic [7:0]       irq_vector,
    input logic [CNT_W-1:0] cur_count,
    input logic             running,
    input logic             mask_bit,
    input logic [7:0]       vec_field
);
    logic start_wr;
    assign start_wr = bus_we && (bus_addr == 2'd0);

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!irq_valid && !running && cur_count == '0)); // R1

    AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
        start_wr |=> (cur_count == $past(bus_wdata[CNT_W-1:0]))); // R2

    AST_ZERO_STOPS: assert property (@(posedge clk) disable iff (rst)
        (start_wr && bus_wdata[CNT_W-1:0] == '0) |=> (!running && !irq_valid)); // R2

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
        (running && !start_wr) |=> ($stable(cur_count)
            || cur_count == $past(cur_count) - CNT_W'(1)
            || $past(cur_count) == CNT_W'(1))); // R4

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!running && !start_wr) |=> ($stable(cur_count) && !irq_valid)); // R6

    AST_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> ($past(running) && !$past(mask_bit))); // R7

    AST_VECTOR_MATCH: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (irq_vector == $past(vec_field))); // R8
endmodule

bind irq_countdown_timer irqtmr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .irq_valid  (irq_valid),
    .irq_vector (irq_vector),
    .cur_count  (cur_q),
    .running    (running_q),
    .mask_bit   (entry_q.masked),
    .vec_field  (entry_q.vector)
);

// File: tb/irq_countdown_timer_test.sv
module irq_countdown_timer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        irq_valid;
    logic [7:0]  irq_vector;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    irq_countdown_timer uut (
        .clk        (clk),
        .rst        (rst),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_valid  (irq_valid),
        .irq_vector (irq_vector)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_irq(input int limit, output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!irq_valid && k < limit);
    endtask

    task automatic count_pulses(input int cycles, output int p);
        p = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (irq_valid) p++;
        end
    endtask

    function automatic int factor_of(input int c);
        return (c == 7) ? 1 : (2 << c);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int k, p, f;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            chk("R1 reg after reset", d, 32'd0);
        end
        chk("R1 irq after reset", {31'd0, irq_valid}, 32'd0);

        // R3 R4 R6 R8 sweep of all divider codes, one-shot, N=3
        for (int c = 0; c < 8; c++) begin
            logic [2:0] cc;
            cc = 3'(c);
            f = factor_of(c);
            wr(2'd3, 32'h40 + c);
            wr(2'd2, 32'hFFFF_FFF4 | {28'd0, cc[2], 1'b0, cc[1], cc[0]});
            rd(2'd2, d);
            chk("R3 divider readback", d, {28'd0, cc[2], 1'b0, cc[1], cc[0]});
            wr(2'd0, 32'd3);
            rd(2'd1, d);
            chk("R2 start loads live count", d, 32'd3);
            k = 0;
            do begin
                @(negedge clk);
                k++;
                if (k == f) begin
                    rd(2'd1, d);
                    chk("R4 first decrement", d, 32'd2);
                end
            end while (!irq_valid && k < 2000);
            chk("R4 expiry time N*F", k, 3 * f);
            chk("R8 vector", {24'd0, irq_vector}, 32'h40 + c);
            @(negedge clk);
            chk("R8 single-cycle pulse", {31'd0, irq_valid}, 32'd0);
            rd(2'd1, d);
            chk("R6 one-shot holds zero", d, 32'd0);
            count_pulses(6 * f + 5, p);
            chk("R6 no repeat in one-shot", p, 0);
        end

        // R5 repeating, factor 4, N=4
        wr(2'd2, 32'h1);
        wr(2'd3, 32'h0002_0077);
        wr(2'd0, 32'd4);
        wait_irq(200, k);
        chk("R5 first period", k, 16);
        rd(2'd1, d);
        chk("R5 reload value", d, 32'd4);
        wait_irq(200, k);
        chk("R5 second period", k, 16);
        wr(2'd0, 32'd0);

        // R5 corner: N=1, factor 1, request every clock
        wr(2'd2, 32'hB);
        wr(2'd0, 32'd1);
        wait_irq(20, k);
        chk("R5 N=1 F=1 first", k, 1);
        wait_irq(20, k);
        chk("R5 N=1 F=1 next", k, 1);
        wr(2'd0, 32'd0);

        // R7 masked repeating, factor 4, N=4
        wr(2'd2, 32'h1);
        wr(2'd3, 32'h0003_0055);
        wr(2'd0, 32'd4);
        count_pulses(40, p);
        chk("R7 masked no request", p, 0);
        rd(2'd1, d);
        chk("R7 counting continues", d, 32'd4 - ((40 / 4) % 4));
        wr(2'd3, 32'h0002_0055);
        wait_irq(40, k);
        chk("R7 unmasked request", {31'd0, irq_valid}, 32'd1);
        chk("R7 vector after unmask", {24'd0, irq_vector}, 32'h55);
        wr(2'd0, 32'd0);

        // R9 entry write mask
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, d);
        chk("R9 entry readback", d, 32'h0003_10FF);
        wr(2'd3, 32'h21);

        // R2 start value 0 stops the timer
        wr(2'd2, 32'hB);
        wr(2'd0, 32'd10);
        repeat (3) @(negedge clk);
        wr(2'd0, 32'd0);
        rd(2'd1, d);
        chk("R2 zero clears count", d, 32'd0);
        count_pulses(30, p);
        chk("R2 zero raises nothing", p, 0);

        // R10 restart while running
        wr(2'd0, 32'd20);
        repeat (5) @(negedge clk);
        wr(2'd0, 32'd7);
        wait_irq(100, k);
        chk("R10 restart period", k, 7);

        // R12 live count is read only
        wr(2'd1, 32'h1234);
        rd(2'd1, d);
        chk("R12 live write ignored", d, 32'd0);
        count_pulses(20, p);
        chk("R12 no start from live write", p, 0);

        // R11 divider write restarts phase (factor 4, N=10)
        wr(2'd2, 32'h1);
        wr(2'd0, 32'd10);
        repeat (2) @(negedge clk);
        wr(2'd2, 32'h1);
        rd(2'd1, d);
        chk("R11 no decrement on divider write", d, 32'd10);
        repeat (3) @(negedge clk);
        rd(2'd1, d);
        chk("R11 window not yet done", d, 32'd10);
        @(negedge clk);
        rd(2'd1, d);
        chk("R11 decrement after F", d, 32'd9);
        wr(2'd0, 32'd0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule